// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A register-mapped general-purpose I/O block for 28 pads. Software selects each pad as input or output, and reads the synchronized level of every pad whatever its direction. It changes the output latch through two write-one registers, one that sets bits and one that clears them, so no read-modify-write is needed. A further register hands pads over to alternate functions. That register is only exported as a vector, and the muxing is done outside the block.

Each pad can watch for rising edges, falling edges, both, or neither. A detected edge sets a sticky status bit, and software clears the bit by writing a one to it. The status drives twelve interrupt request lines. The eleven lowest pads each own a line. The remaining seventeen pads share the last line, which is the OR of their status bits.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, pad_oe, pad_out, alt_sel and irq are all zero.
- R2: The direction word (offset 0x04) is read/write. A 1 bit makes the pad an output, and pad_oe equals the stored word.
- R3: Writing offset 0x08 sets each output latch bit written as 1. Writing offset 0x0C clears each bit written as 1. Bits written 0 keep their value. Both offsets read as zero.
- R4: The level word (offset 0x00) returns pad_in through a two-flop synchronizer. A pad change made between clock edges is visible after the second rising edge, whether the pad is an input or an output.
- R5: The rise-enable word (0x10) and the fall-enable word (0x14) select per pad which edges are detected. The four combinations give none, rising only, falling only, or both.
- R6: The status word (0x18) keeps a bit set once an enabled edge is seen. Writing 1 to a bit clears only that bit, and writing 0 changes nothing.
- R7: irq[i] follows status bit i for pads 0 to 10. irq[11] is the OR of status bits 11 to 27.
- R8: When an enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R9: The alternate-function word (0x1C) is read/write, with 1 meaning alternate function, and alt_sel equals the stored word.
- R10: Data bits 28 to 31 read as zero in every word, and writes to them have no effect.
- R11: A status bit sets on the third rising clock edge after its pad changes, one edge after the synchronized level updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 5 | Byte address of the register word |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| pad_in | input | 28 | Pad input levels |
| pad_out | output | 28 | Output latch |
| pad_oe | output | 28 | Output enables (1 = drive) |
| alt_sel | output | 28 | Alternate-function select |
| irq | output | 12 | Interrupt requests: 0-10 per pad, 11 shared |

## Verification
The bench builds the block with its default parameters: 28 pads, 11 dedicated lines and a 32-bit data word. With these values the split between dedicated and shared interrupt lines falls between pads 10 and 11, so the bench can test both sides of that split. The four unused data bits also exist, so writes to them and reads of them can be checked. The same build lets the bench hit the exact third-edge cycle of an edge, including a clear write made in that same cycle.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] alt_sel,
  output logic [NDIRECT:0] irq
);
  localparam int WAW = AW - 2;
  localparam logic [WAW-1:0] W_LEVEL = WAW'(0);
  localparam logic [WAW-1:0] W_DIR   = WAW'(1);
  localparam logic [WAW-1:0] W_SET   = WAW'(2);
  localparam logic [WAW-1:0] W_CLR   = WAW'(3);
  localparam logic [WAW-1:0] W_RISE  = WAW'(4);
  localparam logic [WAW-1:0] W_FALL  = WAW'(5);
  localparam logic [WAW-1:0] W_STAT  = WAW'(6);
  localparam logic [WAW-1:0] W_ALT   = WAW'(7);

  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] dir_q, out_q, rise_q, fall_q, stat_q, alt_q;
  logic [NPINS-1:0] rd_pins, edge_hit, w1c;
  logic [WAW-1:0]   widx;
  logic [NPINS-1:0] wd;

  assign widx = addr[AW-1:2];
  assign wd   = wdata[NPINS-1:0];

  logic unused_bits;
  assign unused_bits = ^{wdata[DW-1:NPINS], addr[1:0]};

  assign edge_hit = (rise_q & s2 & ~s3) | (fall_q & ~s2 & s3);
  assign w1c      = (we && widx == W_STAT) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      dir_q <= '0; out_q <= '0; rise_q <= '0;
      fall_q <= '0; stat_q <= '0; alt_q <= '0;
    end else begin
      s1 <= pad_in;
      s2 <= s1;
      s3 <= s2;
      stat_q <= (stat_q & ~w1c) | edge_hit;
      if (we) begin
        case (widx)
          W_DIR:   dir_q  <= wd;
          W_SET:   out_q  <= out_q | wd;
          W_CLR:   out_q  <= out_q & ~wd;
          W_RISE:  rise_q <= wd;
          W_FALL:  fall_q <= wd;
          W_ALT:   alt_q  <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      W_LEVEL: rd_pins = s2;
      W_DIR:   rd_pins = dir_q;
      W_RISE:  rd_pins = rise_q;
      W_FALL:  rd_pins = fall_q;
      W_STAT:  rd_pins = stat_q;
      W_ALT:   rd_pins = alt_q;
      default: rd_pins = '0;
    endcase
    rdata = '0;
    rdata[NPINS-1:0] = rd_pins;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign alt_sel = alt_q;
  assign irq     = {|stat_q[NPINS-1:NDIRECT], stat_q[NDIRECT-1:0]};
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32,
  parameter int AW      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             we,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NDIRECT:0] irq,
  input logic [NPINS-1:0] sync_now,
  input logic [NPINS-1:0] sync_old,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en,
  input logic [NPINS-1:0] stat
);
  logic [NPINS-1:0] set_m, clr_m, w1c_m, rise_m, fall_m;
  assign set_m  = (we && addr[AW-1:2] == (AW-2)'(2)) ? wdata[NPINS-1:0] : '0;
  assign clr_m  = (we && addr[AW-1:2] == (AW-2)'(3)) ? wdata[NPINS-1:0] : '0;
  assign w1c_m  = (we && addr[AW-1:2] == (AW-2)'(6)) ? wdata[NPINS-1:0] : '0;
  assign rise_m = rise_en & sync_now & ~sync_old;
  assign fall_m = fall_en & ~sync_now & sync_old;

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((pad_out & $past(set_m)) == $past(set_m)));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != '0) |=> ((pad_out & $past(clr_m)) == '0));
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_m != '0) |=> ((stat & $past(rise_m)) == $past(rise_m)));
  p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_m != '0) |=> ((stat & $past(fall_m)) == $past(fall_m)));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat) & ~$past(w1c_m) & ~stat) == '0));
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> (irq == '0));
  p_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata >> NPINS) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
  .NPINS(NPINS), .NDIRECT(NDIRECT), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .rdata(rdata), .pad_out(pad_out), .irq(irq), .sync_now(s2),
  .sync_old(s3), .rise_en(rise_q), .fall_en(fall_q), .stat(stat_q)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C;
  localparam logic [4:0] A_RISE = 5'h10, A_FALL = 5'h14, A_STAT = 5'h18, A_ALT = 5'h1C;

  logic clk = 0, rst_n = 0, we = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [27:0] pad_in = '0, pad_out, pad_oe, alt_sel;
  logic [11:0] irq;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 alt_sel", 32'(alt_sel), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(A_DIR, 32'h0F0F_0F0F);
    rd(A_DIR, v); chk("R2 dir read", v, 32'h0F0F_0F0F);
    chk("R2 pad_oe", 32'(pad_oe), 32'h0F0F_0F0F);
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, v); chk("R10 dir upper", v, 32'h0FFF_FFFF);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(A_SET, 32'h5);          chk("R3 set", 32'(pad_out), 32'h5);
    wr(A_SET, 32'h10);         chk("R3 set keeps", 32'(pad_out), 32'h15);
    wr(A_CLR, 32'h1);          chk("R3 clr", 32'(pad_out), 32'h14);
    wr(A_SET, 32'hF000_0000);  chk("R10 set upper", 32'(pad_out), 32'h14);
    rd(A_SET, v); chk("R3 set reads 0", v, 0);
    rd(A_CLR, v); chk("R3 clr reads 0", v, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); pad_in = 28'hABC_DEF1;
    clocks(1); rd(A_LVL, v); chk("R4 level early", v, 0);
    clocks(1); rd(A_LVL, v); chk("R4 level", v, 32'h0ABC_DEF1);
    @(negedge clk); pad_in = '0; clocks(3);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    wr(A_RISE, 32'h28);
    wr(A_FALL, 32'h30);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 28'h78;
    clocks(2); rd(A_STAT, v); chk("R11 not yet", v, 0);
    clocks(1); rd(A_STAT, v); chk("R11 R5 rising", v, 32'h28);
    wr(A_STAT, 32'h0);  rd(A_STAT, v); chk("R6 write 0 no effect", v, 32'h28);
    wr(A_STAT, 32'h20); rd(A_STAT, v); chk("R6 clear one bit", v, 32'h08);
    wr(A_STAT, 32'hFF);
    @(negedge clk); pad_in = '0;
    clocks(3); rd(A_STAT, v); chk("R5 falling", v, 32'h30);
    wr(A_STAT, 32'hFF); rd(A_STAT, v); chk("R6 cleared", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_RISE, 32'h0800_0C00);
    @(negedge clk); pad_in[10] = 1; clocks(3);
    chk("R7 pin10 line", 32'(irq), 32'h400);
    wr(A_STAT, 32'h400);
    chk("R7 pin10 cleared", 32'(irq), 0);
    @(negedge clk); pad_in[27] = 1; clocks(3);
    chk("R7 pin27 shared", 32'(irq), 32'h800);
    @(negedge clk); pad_in[11] = 1; clocks(3);
    wr(A_STAT, 32'h0800_0000);
    chk("R7 shared held by pin11", 32'(irq), 32'h800);
    wr(A_STAT, 32'h800);
    chk("R7 shared released", 32'(irq), 0);
    rd(A_STAT, v); chk("R7 status empty", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(A_RISE, 32'h1000);
    wr(A_FALL, 32'h1000);
    @(negedge clk); pad_in[12] = 1; clocks(3);
    rd(A_STAT, v); chk("R8 pre set", v, 32'h1000);
    @(negedge clk); pad_in[12] = 0;
    clocks(1);
    @(negedge clk); addr = A_STAT; wdata = 32'h1000; we = 1;
    @(negedge clk); we = 0;
    rd(A_STAT, v); chk("R8 edge wins", v, 32'h1000);
    wr(A_STAT, 32'h1000);
    rd(A_STAT, v); chk("R8 later clear", v, 0);
  endtask

  task automatic t_alt;
    logic [31:0] v;
    wr(A_ALT, 32'hFFFF_FFFF);
    chk("R9 alt_sel", 32'(alt_sel), 32'h0FFF_FFFF);
    rd(A_ALT, v); chk("R10 alt upper", v, 32'h0FFF_FFFF);
    wr(A_ALT, 32'h5);
    rd(A_ALT, v); chk("R9 alt read", v, 32'h5);
    chk("R9 alt_sel low", 32'(alt_sel), 32'h5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clocks(3);
    rst_n = 1;
    clocks(1);
    t_reset;
    t_dir;
    t_setclr;
    t_level;
    t_edges;
    t_irq;
    t_collide;
    t_alt;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule